// File: doc/BRIEF.md
# USB Error Interrupt Status Collector

This block turns single-cycle error pulses from a USB serial interface engine into a sticky 8-bit status register. Software reads the register and clears the bits it has handled by writing ones to them. An 8-bit enable register sits beside it, and the enabled status bits together produce one summary error flag. The top-level interrupt logic uses that flag as its error bit.

Two status bits carry more than one cause. The bus/DMA bit is set when a descriptor fetch is not granted the bus in time, and also when a packet overruns its allocated buffer. The CRC5/frame bit records a token CRC5 error in peripheral mode. In host mode it records a transfer that is still in progress when the frame countdown reaches zero. The error detectors and the CPU bus decode lie outside this block. The register port is a single write strobe with a one-bit register select.

Top module: `usb_err_collector`

## Requirements
- R1: After reset the status register and the enable register both read 0x00, and `err_any` is low.
- R2: A pulse on an error input sets its status bit on the next rising clock edge. Bit positions: 7 bit stuff, 5 bus/DMA, 4 turnaround timeout, 3 partial-byte data field, 2 CRC16, 1 CRC5/frame end, 0 PID check.
- R3: Status bit 6 always reads 0, and writes to it have no effect.
- R4: A write with `reg_sel`=0 clears each status bit whose `reg_wdata` bit is 1. Bits whose `reg_wdata` bit is 0 are left unchanged.
- R5: If an error pulse and a write-one-to-clear reach the same bit in the same cycle, the bit ends up set.
- R6: Bit 1 is set by `token_crc5_p` when `host_mode`=0 and by `frame_end_p` when `host_mode`=1. The input for the other mode has no effect.
- R7: Bit 5 is set by either `bus_late_p` or `buf_overrun_p`.
- R8: `err_any` equals the OR of all status bits ANDed with their enable bits, in the same cycle as the register contents.
- R9: A write with `reg_sel`=1 loads the enable register, and `reg_sel`=1 reads it back. The enable bits do not change the status bits.
- R10: A set status bit stays set until it is cleared under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host mode, 0 = peripheral mode |
| stuff_err_p | input | 1 | Bit-stuff error pulse |
| bus_late_p | input | 1 | Descriptor fetch not granted in time |
| buf_overrun_p | input | 1 | Packet larger than its buffer |
| turnaround_to_p | input | 1 | Bus turnaround timeout pulse |
| partial_byte_p | input | 1 | Data field not a whole number of bytes |
| crc16_err_p | input | 1 | Data packet CRC16 error |
| token_crc5_p | input | 1 | Token CRC5 error (peripheral mode) |
| frame_end_p | input | 1 | Frame countdown expired during a transfer (host mode) |
| pid_err_p | input | 1 | PID check failure |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status register, 1 = enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| err_any | output | 1 | Summary error flag |

## Verification
The assertions check on every cycle that each error input sets its bit, that set wins over a simultaneous clear, that the mode select routes bit 1 correctly, that set bits persist unless cleared, and that an empty status keeps the summary low. Only the bench scenarios can show the following: the full masked-OR value of the summary under shifting enable patterns, enable readback, and that a written 1 to bit 6 never shows up. They also show that clears and sets interleave correctly over long random sequences.

// File: rtl/usb_err_collector.sv
module usb_err_collector (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_mode,
  input  logic       stuff_err_p,
  input  logic       bus_late_p,
  input  logic       buf_overrun_p,
  input  logic       turnaround_to_p,
  input  logic       partial_byte_p,
  input  logic       crc16_err_p,
  input  logic       token_crc5_p,
  input  logic       frame_end_p,
  input  logic       pid_err_p,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       err_any
);
  localparam int unsigned W = 8;
  localparam logic [W-1:0] LIVE_MASK = 8'hBF;

  logic [W-1:0] stat_q, en_q, set_v, clr_v;
  logic         crc_frame_hit;

  assign crc_frame_hit = host_mode ? frame_end_p : token_crc5_p;

  assign set_v = {stuff_err_p, 1'b0, bus_late_p | buf_overrun_p, turnaround_to_p,
                  partial_byte_p, crc16_err_p, crc_frame_hit, pid_err_p};

  assign clr_v = (reg_wr && !reg_sel) ? (reg_wdata & LIVE_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                en_q <= '0;
    else if (reg_wr && reg_sel) en_q <= reg_wdata;
  end

  assign reg_rdata = reg_sel ? en_q : stat_q;
  assign err_any   = |(stat_q & en_q);

  assert_stuff_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err_p |=> reg_sel || reg_rdata[7]);
  assert_pid_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pid_err_p |=> stat_q[0]);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[2] && crc16_err_p) |=> stat_q[2]);
  assert_crc5_periph_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && token_crc5_p) |=> stat_q[1]);
  assert_eof_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && frame_end_p) |=> stat_q[1]);
  assert_dma_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_late_p || buf_overrun_p) |=> stat_q[5]);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_v)) == $past(stat_q & ~clr_v)));
  assert_quiet_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !err_any);
endmodule

// File: tb/usb_err_collector_tb.sv
`timescale 1ns/1ps
module usb_err_collector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b0;
  logic [8:0] pv = '0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic err_any;

  always #2 clk = ~clk;

  usb_err_collector dut_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .stuff_err_p(pv[8]), .bus_late_p(pv[7]), .buf_overrun_p(pv[6]),
    .turnaround_to_p(pv[5]), .partial_byte_p(pv[4]), .crc16_err_p(pv[3]),
    .token_crc5_p(pv[2]), .frame_end_p(pv[1]), .pid_err_p(pv[0]),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_any(err_any));

  int total = 0, bad = 0;
  logic [7:0] m_stat = '0, m_en = '0;
  bit finished = 0;

  localparam int P_STUFF = 8, P_LATE = 7, P_OVR = 6, P_TA = 5, P_PB = 4,
                 P_CRC16 = 3, P_CRC5 = 2, P_EOF = 1, P_PID = 0;

  function automatic logic [7:0] set_of(input logic [8:0] p, input logic hm);
    return {p[P_STUFF], 1'b0, p[P_LATE] | p[P_OVR], p[P_TA], p[P_PB], p[P_CRC16],
            hm ? p[P_EOF] : p[P_CRC5], p[P_PID]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] p, input logic hm, input logic wr,
                      input logic sel, input logic [7:0] wd, input string req);
    logic [7:0] nstat, nen, clr;
    @(negedge clk);
    pv = p; host_mode = hm; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    #1;
    chk(req, reg_rdata, sel ? m_en : m_stat);
    chk("R8", {7'b0, err_any}, {7'b0, |(m_stat & m_en)});
    clr = (wr && !sel) ? (wd & 8'hBF) : 8'h00;
    nstat = (m_stat & ~clr) | set_of(p, hm);
    nen = (wr && sel) ? wd : m_en;
    @(posedge clk);
    m_stat = nstat; m_en = nen;
  endtask

  task automatic idle_read(input logic sel, input string req);
    step('0, host_mode, 1'b0, sel, 8'h00, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", reg_rdata, 8'h00);
    chk("R1", {7'b0, err_any}, 8'h00);
    idle_read(1'b1, "R1");

    for (int b = 0; b < 9; b++) begin
      if (b == P_EOF) continue;
      step(9'(1 << b), 1'b0, 1'b0, 1'b0, 8'h00, "R2");
      idle_read(1'b0, "R2");
      step('0, 1'b0, 1'b1, 1'b0, 8'hFF, "R4");
    end
    idle_read(1'b0, "R4");
    chk("R4", m_stat, 8'h00);

    step(9'h1FF, 1'b0, 1'b0, 1'b0, 8'h00, "R10");
    step('0, 1'b0, 1'b1, 1'b0, 8'h00, "R10");
    idle_read(1'b0, "R10");
    chk("R3", m_stat, 8'hBF);
    step('0, 1'b0, 1'b1, 1'b0, 8'h0F, "R4");
    idle_read(1'b0, "R4");
    chk("R4", m_stat, 8'hB0);
    step('0, 1'b0, 1'b1, 1'b0, 8'h40, "R3");
    idle_read(1'b0, "R3");
    step('0, 1'b0, 1'b1, 1'b0, 8'hFF, "R4");

    step(9'(1 << P_CRC16), 1'b0, 1'b1, 1'b0, 8'hFF, "R5");
    idle_read(1'b0, "R5");
    chk("R5", m_stat, 8'h04);
    step('0, 1'b0, 1'b1, 1'b0, 8'hFF, "R5");

    step(9'(1 << P_EOF), 1'b0, 1'b0, 1'b0, 8'h00, "R6");
    idle_read(1'b0, "R6");
    step(9'(1 << P_CRC5), 1'b1, 1'b0, 1'b0, 8'h00, "R6");
    idle_read(1'b0, "R6");
    chk("R6", m_stat, 8'h00);
    step(9'(1 << P_EOF), 1'b1, 1'b0, 1'b0, 8'h00, "R6");
    idle_read(1'b0, "R6");
    chk("R6", m_stat, 8'h02);
    step('0, 1'b1, 1'b1, 1'b0, 8'hFF, "R6");
    host_mode = 1'b0;

    step(9'(1 << P_LATE), 1'b0, 1'b0, 1'b0, 8'h00, "R7");
    idle_read(1'b0, "R7");
    step('0, 1'b0, 1'b1, 1'b0, 8'hFF, "R7");
    step(9'(1 << P_OVR), 1'b0, 1'b0, 1'b0, 8'h00, "R7");
    idle_read(1'b0, "R7");
    chk("R7", m_stat, 8'h20);

    step('0, 1'b0, 1'b1, 1'b1, 8'h5A, "R9");
    idle_read(1'b1, "R9");
    idle_read(1'b0, "R9");
    step('0, 1'b0, 1'b1, 1'b1, 8'h20, "R8");
    idle_read(1'b0, "R8");
    step('0, 1'b0, 1'b1, 1'b0, 8'h20, "R8");
    idle_read(1'b0, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] p;
      logic wr;
      p = '0;
      for (int b = 0; b < 9; b++) if ($urandom_range(0, 9) == 0) p[b] = 1'b1;
      wr = ($urandom_range(0, 3) == 0);
      step(p, 1'($urandom_range(0, 1)), wr, 1'($urandom_range(0, 1)),
           8'($urandom), "R10");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule